// File: doc/BRIEF.md
# Shared Odd-Multiple Coefficient Scaler

This block scales one signed channel coefficient by a set of symbol amplitudes without a bank of general multipliers. Symbol amplitudes are restricted to odd multiples of a modulation gain, so every possible product is an odd multiple (1, 3, ..., 15) of the coefficient times that gain. The block forms the coefficient-times-gain base once, through a serial shift-and-add accumulator, then builds and registers the full table of odd multiples with shifts and adds only.

Several output lanes read that one registered table. Each lane has a 3-bit select code that names the odd multiple and a sign bit that negates the chosen value. Each lane is therefore only an 8-way multiplexer followed by a conditional two's-complement negation. A coefficient load starts a rebuild. While the rebuild runs, the lanes keep reading the previous table, so a decoder stage can keep consuming products until the new table lands. The same table serves any coefficient whose symbols come from the same level set.

Top module: `coef_level_scaler`

## Requirements
- R1: While reset is asserted and after its release with no load, `busy_o` is 0 and every lane output is 0 for any select and sign.
- R2: A load seen on a clock edge while `busy_o` is 0 drives `busy_o` high for exactly GAIN_W+1 cycles (9 with defaults). The new table takes effect at the edge where `busy_o` falls.
- R3: With sign 0 and select code s (0..7), a lane outputs (2s+1)·gain·coef as a signed OUT_W-bit value (OUT_W = COEF_W+GAIN_W+4). Code 0 selects ×1 and code 7 selects ×15. The extreme operands coef = −2048 or 2047 with gain = 255 at ×15 do not overflow.
- R4: With sign 1, a lane outputs the two's-complement negation of the value that sign 0 would give.
- R5: All lanes read the same table at the same time, each with its own select and sign, and no lane affects another.
- R6: During a rebuild, lane outputs follow select and sign changes in the same cycle, with values taken from the previous table.
- R7: A load pulse while `busy_o` is 1 is ignored. The rebuild in progress keeps its operands and its GAIN_W+1-cycle window.
- R8: `coef_i` and `gain_i` are sampled only on an accepted load. Changing them at any other time leaves the outputs unchanged.
- R9: A gain of 0 produces a table of zeros, so every lane outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a table rebuild from coef_i and gain_i |
| coef_i | input | COEF_W | Signed channel coefficient |
| gain_i | input | GAIN_W | Unsigned modulation gain |
| sel_i | input | NUM_OUT·SEL_W | Per-lane select code, lane l in bits [l·SEL_W +: SEL_W] |
| neg_i | input | NUM_OUT | Per-lane sign, 1 negates |
| prod_o | output | NUM_OUT·OUT_W | Per-lane signed product, lane l in bits [l·OUT_W +: OUT_W] |
| busy_o | output | 1 | Rebuild in progress |

## Verification
The two functions that overlap are the multiplexer read-out and the table rebuild. A lane can change its select in the same cycle that the serial accumulator is mid-way through a new coefficient. The bench provokes this by loading a new coefficient, then changing every lane's select and sign on a busy cycle, re-pulsing load and changing the coefficient and gain inputs. It expects products from the old table, a busy window of exactly nine cycles, and afterwards products of the first loaded operands only.

// File: rtl/cls_pkg.sv
package cls_pkg;
  // Control states of the serial base accumulator.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_BUILD = 2'd2
  } gain_state_e;
endpackage

// File: rtl/cls_gain_serial.sv
// Serial shift-and-add: coef * gain over GAIN_W cycles, then one build cycle.
module cls_gain_serial #(
  parameter int COEF_W = 12,
  parameter int GAIN_W = 8,
  localparam int PW    = COEF_W + GAIN_W,
  localparam int CNT_W = $clog2(GAIN_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [COEF_W-1:0]    coef_i,
  input  logic [GAIN_W-1:0]    gain_i,
  output logic                 busy_o,
  output logic                 build_o,
  output logic signed [PW-1:0] base_o
);
  import cls_pkg::*;

  gain_state_e          state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic signed [PW-1:0] acc_q, acc_d;
  logic signed [PW-1:0] mcand_q, mcand_d;
  logic [GAIN_W-1:0]    mplier_q, mplier_d;
  logic                 dp_en;

  // next-state and datapath
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    dp_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          dp_en    = 1'b1;
          state_d  = ST_RUN;
          cnt_d    = '0;
          acc_d    = '0;
          mcand_d  = {{GAIN_W{coef_i[COEF_W-1]}}, coef_i};
          mplier_d = gain_i;
        end
      end
      ST_RUN: begin
        dp_en    = 1'b1;
        if (mplier_q[0]) acc_d = acc_q + mcand_q;
        mcand_d  = mcand_q <<< 1;
        mplier_d = mplier_q >> 1;
        cnt_d    = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(GAIN_W - 1)) state_d = ST_BUILD;
      end
      ST_BUILD: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // datapath registers, enabled only while accepting or accumulating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (dp_en) begin
      cnt_q    <= cnt_d;
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign build_o = (state_q == ST_BUILD);
  assign base_o  = acc_q;
endmodule

// File: rtl/cls_odd_bank.sv
// Registered table of odd multiples (1,3,..,2*LEVELS-1) of the base value.
module cls_odd_bank #(
  parameter int IN_W   = 20,
  parameter int LEVELS = 8,
  parameter int OUT_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_i,
  input  logic signed [IN_W-1:0]  base_i,
  output logic [LEVELS*OUT_W-1:0] bank_o
);
  localparam int KB = $clog2(2 * LEVELS) + 1;

  logic signed [OUT_W-1:0] base_x;
  assign base_x = {{(OUT_W-IN_W){base_i[IN_W-1]}}, base_i};

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int K    = 2 * g + 1;
    localparam bit ALL1 = ((K + 1) & K) == 0;
    localparam int NSH  = $clog2(K + 1);

    logic signed [OUT_W-1:0] mult_d;
    logic signed [OUT_W-1:0] mult_q;

    if (ALL1) begin : g_sub
      // all-ones multiplier: one shift and one subtract
      assign mult_d = (base_x <<< NSH) - base_x;
    end else begin : g_add
      always_comb begin
        mult_d = '0;
        for (int b = 0; b < KB; b++)
          if (K[b]) mult_d = mult_d + (base_x <<< b);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mult_q <= '0;
      else if (cap_i) mult_q <= mult_d;
    end

    assign bank_o[g*OUT_W +: OUT_W] = mult_q;
  end
endmodule

// File: rtl/cls_pick.sv
// One output lane: select an odd multiple, then apply the sign.
module cls_pick #(
  parameter int OUT_W  = 24,
  parameter int LEVELS = 8,
  localparam int SEL_W = $clog2(LEVELS)
) (
  input  logic [LEVELS*OUT_W-1:0] bank_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic                    neg_i,
  output logic [OUT_W-1:0]        prod_o
);
  logic [OUT_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < LEVELS; i++)
      if (sel_i == SEL_W'(i)) picked = bank_i[i*OUT_W +: OUT_W];
  end

  assign prod_o = neg_i ? (~picked + 1'b1) : picked;
endmodule

// File: rtl/coef_level_scaler.sv
module coef_level_scaler #(
  parameter int COEF_W  = 12,
  parameter int GAIN_W  = 8,
  parameter int NUM_OUT = 4,
  parameter int LEVELS  = 8,
  localparam int SEL_W  = $clog2(LEVELS),
  localparam int BASE_W = COEF_W + GAIN_W,
  localparam int OUT_W  = BASE_W + $clog2(2 * LEVELS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [COEF_W-1:0]        coef_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic [NUM_OUT*SEL_W-1:0] sel_i,
  input  logic [NUM_OUT-1:0]       neg_i,
  output logic [NUM_OUT*OUT_W-1:0] prod_o,
  output logic                     busy_o
);
  logic                     build;
  logic signed [BASE_W-1:0] base;
  logic [LEVELS*OUT_W-1:0]  bank;

  cls_gain_serial #(.COEF_W(COEF_W), .GAIN_W(GAIN_W)) u_gain (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (load_i),
    .coef_i  (coef_i),
    .gain_i  (gain_i),
    .busy_o  (busy_o),
    .build_o (build),
    .base_o  (base)
  );

  cls_odd_bank #(.IN_W(BASE_W), .LEVELS(LEVELS), .OUT_W(OUT_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (build),
    .base_i (base),
    .bank_o (bank)
  );

  for (genvar l = 0; l < NUM_OUT; l++) begin : g_lane
    cls_pick #(.OUT_W(OUT_W), .LEVELS(LEVELS)) u_pick (
      .bank_i (bank),
      .sel_i  (sel_i[l*SEL_W +: SEL_W]),
      .neg_i  (neg_i[l]),
      .prod_o (prod_o[l*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/cls_checker.sv
module cls_checker #(
  parameter int COEF_W  = 12,
  parameter int GAIN_W  = 8,
  parameter int NUM_OUT = 4,
  parameter int LEVELS  = 8,
  localparam int SEL_W  = $clog2(LEVELS),
  localparam int OUT_W  = COEF_W + GAIN_W + $clog2(2 * LEVELS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     load_i,
  input logic [NUM_OUT*SEL_W-1:0] sel_i,
  input logic [NUM_OUT-1:0]       neg_i,
  input logic [NUM_OUT*OUT_W-1:0] prod_o,
  input logic                     busy_o
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  // R2 and R7: every busy window lasts exactly GAIN_W+1 cycles, reloads or not
  a_r2_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_run == GAIN_W + 1);

  // R2: busy only starts after a sampled load
  a_r2_start_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(load_i));

  // R6: old table held during rebuild
  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $stable(sel_i) && $stable(neg_i)) |-> $stable(prod_o));

  if (NUM_OUT > 1) begin : g_pair
    logic [SEL_W-1:0]        s0, s1;
    logic signed [OUT_W-1:0] p0, p1;
    assign s0 = sel_i[SEL_W-1:0];
    assign s1 = sel_i[2*SEL_W-1:SEL_W];
    assign p0 = prod_o[OUT_W-1:0];
    assign p1 = prod_o[2*OUT_W-1:OUT_W];

    // R4: equal selects with opposite signs give negated values
    a_r4_neg_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (s0 == s1 && neg_i[0] != neg_i[1]) |-> (p1 == -p0));

    // R3: code s gives (2s+1) times the code-0 value
    a_r3_odd_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      (!neg_i[0] && !neg_i[1] && s1 == '0) |->
        (longint'(p0) == longint'(p1) * (2 * longint'(s0) + 1)));
  end
endmodule

bind coef_level_scaler cls_checker #(
  .COEF_W(COEF_W), .GAIN_W(GAIN_W), .NUM_OUT(NUM_OUT), .LEVELS(LEVELS)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load_i (load_i),
  .sel_i  (sel_i),
  .neg_i  (neg_i),
  .prod_o (prod_o),
  .busy_o (busy_o)
);

// File: tb/sim_coef_level_scaler.sv
`timescale 1ns/1ps
module sim_coef_level_scaler;
  localparam int COEF_W  = 12;
  localparam int GAIN_W  = 8;
  localparam int NUM_OUT = 4;
  localparam int LEVELS  = 8;
  localparam int SEL_W   = 3;
  localparam int OUT_W   = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic load_i;
  logic [COEF_W-1:0]        coef_i;
  logic [GAIN_W-1:0]        gain_i;
  logic [NUM_OUT*SEL_W-1:0] sel_i;
  logic [NUM_OUT-1:0]       neg_i;
  logic [NUM_OUT*OUT_W-1:0] prod_o;
  logic                     busy_o;

  always #10 clk = ~clk;

  coef_level_scaler #(.COEF_W(COEF_W), .GAIN_W(GAIN_W), .NUM_OUT(NUM_OUT), .LEVELS(LEVELS)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .coef_i(coef_i), .gain_i(gain_i),
    .sel_i(sel_i), .neg_i(neg_i), .prod_o(prod_o), .busy_o(busy_o));

  typedef struct {
    int     lane;
    longint expv;
    string  req;
  } item_t;

  item_t  sb_q[$];
  event   chk_ev;
  int     n_vec  = 0;
  int     n_fail = 0;
  bit     done   = 0;
  longint cur_r  = 0;
  longint cur_d  = 0;

  task automatic check_val(string req, longint act, longint expv);
    n_vec++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: pops expected items and compares against the lane outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check_val($sformatf("%s lane%0d", it.req, it.lane),
                  longint'($signed(prod_o[it.lane*OUT_W +: OUT_W])), it.expv);
      end
    end
  end

  // driver: set lane controls, push expectations from the model table
  task automatic drive_lanes(logic [NUM_OUT*SEL_W-1:0] sels, logic [NUM_OUT-1:0] negs, string req);
    sel_i = sels;
    neg_i = negs;
    for (int l = 0; l < NUM_OUT; l++) begin
      item_t  it;
      longint s;
      s       = longint'(sels[l*SEL_W +: SEL_W]);
      it.lane = l;
      it.expv = cur_r * cur_d * (2 * s + 1);
      if (negs[l]) it.expv = -it.expv;
      it.req  = req;
      sb_q.push_back(it);
    end
    #2 -> chk_ev;
    #1;
  endtask

  // load; optional probe during the busy window (R6, R7, R8)
  task automatic do_load(int r, int d, bit probe);
    int n;
    @(negedge clk);
    coef_i = COEF_W'(r);
    gain_i = GAIN_W'(d);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    n = 0;
    while (busy_o === 1'b1 && n < 40) begin
      n++;
      if (probe && n == 2) begin
        load_i = 1'b1;
        coef_i = COEF_W'(-77);
        gain_i = GAIN_W'(200);
        drive_lanes({3'd7, 3'd2, 3'd5, 3'd0}, 4'b1010, "R6 old table during rebuild");
      end
      if (probe && n == 3) begin
        load_i = 1'b0;
        drive_lanes({3'd1, 3'd6, 3'd3, 3'd4}, 4'b0101, "R6 select change during rebuild");
      end
      @(negedge clk);
    end
    check_val("R2 busy window length", longint'(n), longint'(GAIN_W + 1));
    if (probe) check_val("R7 busy cleared after ignored reload", longint'(busy_o), 0);
    cur_r = longint'(r);
    cur_d = longint'(d);
  endtask

  initial begin
    rst_n  = 1'b0;
    load_i = 1'b0;
    coef_i = '0;
    gain_i = '0;
    sel_i  = '0;
    neg_i  = '0;
    repeat (2) @(negedge clk);
    check_val("R1 busy in reset", longint'(busy_o), 0);
    drive_lanes({3'd7, 3'd3, 3'd1, 3'd0}, 4'b0110, "R1 zero in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R1 busy after reset", longint'(busy_o), 0);
    drive_lanes({3'd4, 3'd5, 3'd6, 3'd7}, 4'b1111, "R1 zero after reset");

    // R3, R4, R5: basic table
    do_load(5, 3, 1'b0);
    drive_lanes({3'd3, 3'd2, 3'd1, 3'd0}, 4'b0000, "R3 codes 0..3");
    drive_lanes({3'd7, 3'd6, 3'd5, 3'd4}, 4'b0000, "R3 codes 4..7");
    drive_lanes({3'd7, 3'd6, 3'd5, 3'd4}, 4'b1111, "R4 all negated");
    drive_lanes({3'd0, 3'd0, 3'd7, 3'd7}, 4'b0110, "R5 independent lanes");

    // R3 extremes
    do_load(-2048, 255, 1'b0);
    drive_lanes({3'd7, 3'd7, 3'd0, 3'd7}, 4'b0100, "R3 min coef x15");
    drive_lanes({3'd7, 3'd7, 3'd7, 3'd7}, 4'b1111, "R4 negated min coef x15");
    do_load(2047, 255, 1'b0);
    drive_lanes({3'd7, 3'd3, 3'd7, 3'd0}, 4'b0010, "R3 max coef x15");

    // R6, R7, R8: rebuild probe; result must be the first loaded operands
    do_load(-300, 11, 1'b1);
    drive_lanes({3'd7, 3'd5, 3'd2, 3'd1}, 4'b0011, "R7 reload ignored");

    // R8: operand changes without load
    @(negedge clk);
    coef_i = COEF_W'(999);
    gain_i = GAIN_W'(17);
    repeat (3) @(negedge clk);
    drive_lanes({3'd6, 3'd4, 3'd2, 3'd0}, 4'b1001, "R8 inputs ignored without load");
    check_val("R8 busy stays low", longint'(busy_o), 0);

    // R9: zero gain
    do_load(1234, 0, 1'b0);
    drive_lanes({3'd7, 3'd6, 3'd1, 3'd0}, 4'b1010, "R9 zero gain");

    // R5: mixed pattern after a further load
    do_load(-1, 129, 1'b0);
    drive_lanes({3'd2, 3'd4, 3'd6, 3'd3}, 4'b1100, "R5 mixed lanes");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule